// File: doc/BRIEF.md
# DAC serial write controller

This block sits on the host side of a three-wire link to a 16-bit voltage-output DAC. A client offers a request with a 16-bit output code and a 2-bit power mode on a valid/ready handshake. The block then builds a 24-bit word and sends it most significant bit first. The serial clock comes from the system clock through a half-period divider. Sync is held low for the whole word. After the word, sync is held high for a minimum time before another word may start.

The DAC samples its data input on falling serial-clock edges. For that reason the clock idles low, each bit changes only on a rising edge, and each bit stays stable through the following fall. At the top of the word are six padding bits, all driven as zero. The two mode bits follow them, and the code comes last. Mode 0 is normal output. Modes 1, 2 and 3 are the three power-down states. The block copies the mode field into the word unchanged.

Timing is set by two parameters: `SCLK_HALF` (system clocks per serial half-period) and `GAP_CYCLES` (system clocks in the sync-high gap). Elaboration checks compare them against the serial clock ceiling (30 MHz) and the minimum sync-high time (33 ns) at the stated system clock rate.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, sync is high, the serial clock is low, the data line is low and ready is high.
- R2: Each word is 24 bits, sent MSB first. Bits 23..18 are zero, bits 17..16 carry the mode, and bits 15..0 carry the code.
- R3: Sync goes low on the clock edge that accepts a request. The serial clock then falls exactly 24 times while sync is low. Sync returns high 49*SCLK_HALF system clocks after it fell.
- R4: While sync is low, the data line changes only on the edge where the serial clock rises. It is therefore stable for the whole high phase and at every fall.
- R5: Each serial-clock half-period lasts SCLK_HALF system clocks. Fall k (k = 1..24) occurs 2*SCLK_HALF*k clocks after sync fell. The serial clock is low whenever sync is high.
- R6: Sync stays high for at least GAP_CYCLES system clocks between two words.
- R7: Ready is low from the accepting edge until 49*SCLK_HALF+GAP_CYCLES edges later, and it is never high while sync is low. A request offered while ready is low is held off and sent later, not dropped.
- R8: All four mode values (0 = normal, 1/2/3 = power-down) appear unchanged in bits 17..16 of the word.
- R9: Code and mode are captured on the accepting edge. Changes on the request inputs after that edge do not alter the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_code | input | 16 | DAC output code |
| req_mode | input | 2 | Power mode field |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sync_n | output | 1 | Active-low frame sync |
| dac_sdo | output | 1 | Serial data to the DAC |

## Verification
Every result is timed from the edge that accepts a request. Sync is seen low one sample after acceptance. Fall k of the serial clock is due 2*SCLK_HALF*k clocks after sync fell. Sync rises 49*SCLK_HALF clocks after it fell, and ready rises GAP_CYCLES clocks after that. The monitor counts falling-edge samples from the sync fall and compares each event against these exact cycle offsets. It collects the bits at each fall and compares the finished word with the next entry the driver queued. Inputs are driven 2 ns after the rising edge and outputs are sampled on the falling edge, so every comparison lands in a settled cycle.

// File: rtl/dacw_pkg.sv
`timescale 1ns/1ps
package dacw_pkg;
   localparam int DEF_PAD_W  = 6;
   localparam int DEF_MODE_W = 2;
   localparam int DEF_CODE_W = 16;

   typedef enum logic [1:0] {
      PWR_ACTIVE    = 2'b00,
      PWR_DOWN_1K   = 2'b01,
      PWR_DOWN_100K = 2'b10,
      PWR_DOWN_OPEN = 2'b11
   } pwr_mode_e;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_LOW,
      SEQ_HIGH,
      SEQ_TAIL,
      SEQ_GAP
   } seq_state_e;
endpackage

// File: rtl/dacw_frame_pack.sv
`timescale 1ns/1ps
// Assembles the outgoing word: zero padding, mode field, code field.
module dacw_frame_pack #(
   parameter int PAD_W   = 6,
   parameter int MODE_W  = 2,
   parameter int CODE_W  = 16,
   localparam int FRAME_W = PAD_W + MODE_W + CODE_W
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic [CODE_W-1:0]  code,
   output logic [FRAME_W-1:0] frame
);
   generate
      if (PAD_W > 0) begin : g_padded
         assign frame = {{PAD_W{1'b0}}, mode, code};
      end else begin : g_bare
         assign frame = {mode, code};
      end
   endgenerate
endmodule

// File: rtl/dacw_interval.sv
`timescale 1ns/1ps
// Counts LIMIT cycles while run is high; done marks the last one and restarts.
module dacw_interval #(
   parameter int LIMIT = 3,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || done) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dacw_seq.sv
`timescale 1ns/1ps
// Word sequencer: accept, clock out the bits, hold sync, then the gap.
module dacw_seq
   import dacw_pkg::*;
#(
   parameter int FRAME_W = 24,
   localparam int IDX_W  = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               half_done,
   input  logic               gap_done,
   output logic               req_ready,
   output logic               half_run,
   output logic               gap_run,
   output logic               sclk,
   output logic               sync_n,
   output logic               sdo
);
   seq_state_e         state;
   logic [FRAME_W-1:0] shreg;
   logic [IDX_W-1:0]   bit_idx;
   logic               last_bit;

   assign last_bit  = (bit_idx == IDX_W'(FRAME_W - 1));
   assign req_ready = (state == SEQ_IDLE);
   assign half_run  = (state == SEQ_LOW) || (state == SEQ_HIGH) || (state == SEQ_TAIL);
   assign gap_run   = (state == SEQ_GAP);
   assign sdo       = shreg[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         shreg   <= '0;
         bit_idx <= '0;
         sclk    <= 1'b0;
         sync_n  <= 1'b1;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (req_valid) begin
                  shreg   <= frame_in;
                  bit_idx <= '0;
                  sync_n  <= 1'b0;
                  state   <= SEQ_LOW;
               end
            end
            SEQ_LOW: begin
               if (half_done) begin
                  sclk  <= 1'b1;
                  state <= SEQ_HIGH;
                  if (bit_idx != '0) begin
                     shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  end
               end
            end
            SEQ_HIGH: begin
               if (half_done) begin
                  sclk <= 1'b0;
                  if (last_bit) begin
                     state <= SEQ_TAIL;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     state   <= SEQ_LOW;
                  end
               end
            end
            SEQ_TAIL: begin
               if (half_done) begin
                  sync_n <= 1'b1;
                  shreg  <= '0;
                  state  <= SEQ_GAP;
               end
            end
            SEQ_GAP: begin
               if (gap_done) begin
                  state <= SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dac_serial_writer.sv
`timescale 1ns/1ps
module dac_serial_writer
   import dacw_pkg::*;
#(
   parameter int PAD_W        = DEF_PAD_W,
   parameter int MODE_W       = DEF_MODE_W,
   parameter int CODE_W       = DEF_CODE_W,
   parameter int SCLK_HALF    = 3,
   parameter int GAP_CYCLES   = 5,
   parameter int SYS_CLK_KHZ  = 125000,
   parameter int SCLK_MAX_KHZ = 30000,
   parameter int SYNC_GAP_NS  = 33,
   localparam int FRAME_W     = PAD_W + MODE_W + CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CODE_W-1:0] req_code,
   input  logic [MODE_W-1:0] req_mode,
   output logic              dac_sclk,
   output logic              dac_sync_n,
   output logic              dac_sdo
);
   // Elaboration-time parameter checks
   generate
      if (SCLK_HALF < 1 || GAP_CYCLES < 1) begin : g_bad_counts
         $error("dac_serial_writer: SCLK_HALF and GAP_CYCLES must be at least 1");
      end
      if (MODE_W < 1 || CODE_W < 2 || PAD_W < 0) begin : g_bad_widths
         $error("dac_serial_writer: field widths out of range");
      end
      if (longint'(SYS_CLK_KHZ) > longint'(2) * SCLK_HALF * SCLK_MAX_KHZ) begin : g_sclk_fast
         $error("dac_serial_writer: serial clock would exceed its ceiling");
      end
      if (longint'(GAP_CYCLES) * 1000000 < longint'(SYNC_GAP_NS) * SYS_CLK_KHZ) begin : g_gap_short
         $error("dac_serial_writer: sync-high gap shorter than the minimum");
      end
   endgenerate

   logic [FRAME_W-1:0] frame;
   logic half_run, half_done, gap_run, gap_done;

   dacw_frame_pack #(
      .PAD_W (PAD_W),
      .MODE_W(MODE_W),
      .CODE_W(CODE_W)
   ) u_pack (
      .mode (req_mode),
      .code (req_code),
      .frame(frame)
   );

   dacw_interval #(.LIMIT(SCLK_HALF)) u_half (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (half_run),
      .done (half_done)
   );

   dacw_interval #(.LIMIT(GAP_CYCLES)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (gap_run),
      .done (gap_done)
   );

   dacw_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .frame_in (frame),
      .half_done(half_done),
      .gap_done (gap_done),
      .req_ready(req_ready),
      .half_run (half_run),
      .gap_run  (gap_run),
      .sclk     (dac_sclk),
      .sync_n   (dac_sync_n),
      .sdo      (dac_sdo)
   );
endmodule

// File: rtl/dacw_checker.sv
`timescale 1ns/1ps
module dacw_checker #(
   parameter int SCLK_HALF  = 3,
   parameter int GAP_CYCLES = 5,
   parameter int FRAME_W    = 24,
   localparam int HW = $clog2(SCLK_HALF + 2) + 1,
   localparam int GW = $clog2(GAP_CYCLES + 2) + 1,
   localparam int FW = $clog2(FRAME_W + 2) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic dac_sclk,
   input logic dac_sync_n,
   input logic dac_sdo
);
   logic [HW-1:0] hi_cnt;
   logic [GW-1:0] gap_cnt;
   logic [FW-1:0] fall_cnt;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= '0;
         gap_cnt  <= GW'(GAP_CYCLES);
         fall_cnt <= '0;
         sclk_q   <= 1'b0;
      end else begin
         sclk_q <= dac_sclk;
         hi_cnt <= dac_sclk ? hi_cnt + 1'b1 : '0;
         if (!dac_sync_n) gap_cnt <= '0;
         else if (gap_cnt < GW'(GAP_CYCLES)) gap_cnt <= gap_cnt + 1'b1;
         if (dac_sync_n) fall_cnt <= '0;
         else if (sclk_q && !dac_sclk) fall_cnt <= fall_cnt + 1'b1;
      end
   end

   assert_idle_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sync_n |-> !dac_sclk);

   assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sclk) |-> (hi_cnt == HW'(SCLK_HALF)));

   assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));

   assert_sync_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_sync_n) |-> (gap_cnt >= GW'(GAP_CYCLES)));

   assert_fall_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_sync_n) |-> (fall_cnt == FW'(FRAME_W)));

   assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_sync_n |-> !req_ready);
endmodule

bind dac_serial_writer dacw_checker #(
   .SCLK_HALF (SCLK_HALF),
   .GAP_CYCLES(GAP_CYCLES),
   .FRAME_W   (FRAME_W)
) u_dacw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .dac_sclk  (dac_sclk),
   .dac_sync_n(dac_sync_n),
   .dac_sdo   (dac_sdo)
);

// File: tb/test_dac_serial_writer.sv
`timescale 1ns/1ps
module test_dac_serial_writer;
   localparam int H     = 3;
   localparam int G     = 5;
   localparam int FRAME = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_code = '0;
   logic [1:0]  req_mode = '0;
   logic        dac_sclk, dac_sync_n, dac_sdo;

   always #4 clk = ~clk;

   dac_serial_writer #(.SCLK_HALF(H), .GAP_CYCLES(G)) i_dac_serial_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_code(req_code), .req_mode(req_mode),
      .dac_sclk(dac_sclk), .dac_sync_n(dac_sync_n), .dac_sdo(dac_sdo)
   );

   int nchk = 0;
   int nfail = 0;
   int sent = 0;
   bit finished = 0;
   logic [23:0] expq[$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Driver: offers one request, waits while held off, queues the expected word
   task automatic send(input logic [15:0] code, input logic [1:0] mode);
      @(posedge clk); #2;
      req_valid = 1'b1;
      req_code  = code;
      req_mode  = mode;
      while (!req_ready) begin
         @(posedge clk); #2;
      end
      expq.push_back({6'b0, mode, code});
      sent++;
      @(posedge clk); #2;
      req_valid = 1'b0;
      req_code  = ~code;   // R9: later input changes must not reach the word
      req_mode  = ~mode;
   endtask

   // Monitor / scoreboard
   bit          mon_en = 0;
   int          cyc = 0, fs = 0, rise_cyc = 0, frames_done = 0;
   int          nfall = 0, pos_err = 0, chg_err = 0, rdy_err = 0, idle_err = 0;
   logic [23:0] got = '0, exp_w;
   logic        p_sclk = 0, p_sync = 1, p_sdo = 0, p_ready = 1;

   always @(negedge clk) begin
      if (mon_en) begin
         cyc++;
         if (p_sync && !dac_sync_n) begin
            fs = cyc; got = '0; nfall = 0; pos_err = 0; chg_err = 0; rdy_err = 0;
            if (frames_done > 0)
               chk(cyc - rise_cyc >= G, "R6 sync-high gap", cyc - rise_cyc, G);
            chk(idle_err == 0, "R5 clock low while sync high", idle_err, 0);
            idle_err = 0;
         end
         if (!dac_sync_n) begin
            if (req_ready) rdy_err++;
            if (p_sclk && !dac_sclk) begin
               nfall++;
               got = {got[22:0], dac_sdo};
               if (cyc != fs + 2 * H * nfall) pos_err++;
            end
            if (dac_sdo !== p_sdo && !(dac_sclk && !p_sclk) && !p_sync) chg_err++;
         end else if (dac_sclk) begin
            idle_err++;
         end
         if (!p_sync && dac_sync_n) begin
            rise_cyc = cyc;
            frames_done++;
            if (expq.size() == 0) begin
               chk(0, "R7 unexpected word", got, 0);
            end else begin
               exp_w = expq.pop_front();
               chk(got == exp_w, "R2/R9 word content", got, exp_w);
               chk(got[23:18] == 6'b0, "R2 zero padding", got[23:18], 0);
               chk(got[17:16] == exp_w[17:16], "R8 mode field", got[17:16], exp_w[17:16]);
            end
            chk(nfall == FRAME, "R3 falling edge count", nfall, FRAME);
            chk(cyc - fs == 49 * H, "R3 sync low duration", cyc - fs, 49 * H);
            chk(pos_err == 0, "R5 falling edge timing", pos_err, 0);
            chk(chg_err == 0, "R4 data changes only on rise", chg_err, 0);
            chk(rdy_err == 0, "R7 ready low during word", rdy_err, 0);
         end
         if (req_ready && !p_ready && frames_done > 0)
            chk(cyc - fs == 49 * H + G, "R7 ready return time", cyc - fs, 49 * H + G);
         p_sclk = dac_sclk; p_sync = dac_sync_n; p_sdo = dac_sdo; p_ready = req_ready;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dac_sync_n == 1'b1, "R1 sync in reset", dac_sync_n, 1);
      chk(dac_sclk == 1'b0, "R1 sclk in reset", dac_sclk, 0);
      chk(dac_sdo == 1'b0, "R1 sdo in reset", dac_sdo, 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      mon_en = 1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(dac_sync_n == 1'b1 && dac_sclk == 1'b0, "R1 idle lines after reset",
          {dac_sync_n, dac_sclk}, 2'b10);

      send(16'h0000, 2'd0);
      send(16'hFFFF, 2'd3);
      repeat (20) @(posedge clk);
      send(16'hA5C3, 2'd1);
      send(16'h8000, 2'd2);
      send(16'h7FFF, 2'd0);
      // back-to-back: each next request is offered while busy (R7 hold-off)
      send(16'h1234, 2'd2);
      send(16'hFEDC, 2'd1);
      send(16'h0001, 2'd3);

      while (expq.size() != 0 || !req_ready) @(posedge clk);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(frames_done == sent, "R7 no request dropped", frames_done, sent);
      chk(dac_sync_n == 1'b1 && dac_sclk == 1'b0, "R5 idle after traffic",
          {dac_sync_n, dac_sclk}, 2'b10);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nfail++;
         $display("FAIL watchdog R7 run hung actual=%0d expected=%0d", frames_done, sent);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule